// File: doc/BRIEF.md
# Multi-Unit Startup Sequencer

This block coordinates a synchronized start across several acquisition units. Each unit first locks its frequency timebase. Then one unit, the exporter, drives a shared sync pulse. Every unit holds its own converters in reset while that pulse lands and while the converters settle. The exporter then withholds the shared start trigger for a programmed minimum delay. Software sets that delay to at least the longest settling time of any importer, counted in the exporter's own sample strobes. Because the slowest unit is the one that exports, its strobes give the longest delay.

Importers are armed before the exporter fires. Once armed, an importer waits for the trigger on its trigger input. The exporter fires the trigger either when software commands a start or, if the command came early, at the moment its delay expires. Every unit therefore enters the running state on the same trigger.

All inputs are synchronous to `clk`. The block has no data stream, so every pin is plain control or status.

Top module: `startup_seq`

## Requirements
- R1: After reset, `seq_state` is 0 (IDLE) and `sync_out`, `trig_out`, `conv_rst`, `armed` and `running` are all low.
- R2: `seq_begin` moves the block from IDLE to SYNCING only when `tb_locked` is high, and it captures `cfg_master` as the mode. Without lock the block stays in IDLE.
- R3: In master mode, SYNCING lasts exactly SYNC_LEN cycles with `sync_out` high. `conv_rst` is high in those cycles and throughout SETTLING.
- R4: On entry to SETTLING, the block loads the count from `cfg_delay` in master mode or from `cfg_settle` in slave mode. Each `rate_stb` cycle decrements the count. The block leaves SETTLING on the clock after the count reaches zero, so a count of 0 gives exactly one SETTLING cycle.
- R5: A master in ARMED moves to RUNNING when `start_cmd` is high. `trig_out` is high for exactly the first RUNNING cycle.
- R6: A master holds a `start_cmd` that arrives in SYNCING or SETTLING. When the count expires, it goes straight to RUNNING with the one-cycle `trig_out` and needs no further command.
- R7: A slave waits in SYNCING with `conv_rst` low until `sync_in` is high. It then enters SETTLING with `conv_rst` high and reaches ARMED after `cfg_settle` strobes.
- R8: A slave in ARMED moves to RUNNING when `trig_in` is high. A slave never drives `trig_out` or `sync_out`, and `start_cmd` has no effect on it.
- R9: `trig_in` has no effect in master mode, and has no effect in slave mode outside ARMED.
- R10: `abort` returns the block to IDLE on the next clock from any state. It also discards a held start command.
- R11: `seq_state` encodes IDLE=0, SYNCING=1, SETTLING=2, ARMED=3 and RUNNING=4. `armed` is high exactly in ARMED and `running` is high exactly in RUNNING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = exporter (master), 0 = importer (slave); captured at begin |
| cfg_delay | input | DLY_W | Master minimum delay from sync to trigger, in sample strobes |
| cfg_settle | input | SET_W | Slave converter settle time, in sample strobes |
| tb_locked | input | 1 | Frequency timebase is locked |
| seq_begin | input | 1 | Begin the sync sequence |
| rate_stb | input | 1 | One-cycle sample-rate strobe |
| start_cmd | input | 1 | Software start command (master only) |
| abort | input | 1 | Return to IDLE |
| sync_in | input | 1 | Imported sync pulse |
| trig_in | input | 1 | Imported start trigger |
| sync_out | output | 1 | Exported sync pulse |
| trig_out | output | 1 | Exported start trigger, one cycle |
| conv_rst | output | 1 | Local converter reset |
| armed | output | 1 | Waiting for the start |
| running | output | 1 | Acquisition started |
| seq_state | output | 3 | Sequencer state code |

## Verification
The bench goes after the off-by-one edges of the strobe count. A zero count must give exactly one SETTLING cycle; a design that decrements before testing for zero would hang or leave a cycle early. It also issues a start command during SETTLING and during the very cycle of expiry; a design that drops the held command would sit in ARMED and never fire the trigger. A `trig_in` is sent while a master is armed and while a slave is still settling; a design that does not gate the trigger by mode and state would start early and lose alignment. Finally, an abort with a held start followed by a fresh sequence must end in ARMED, not RUNNING, which exposes a held command that outlives the abort.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SYNC   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_ARMED  = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;
endpackage

// File: rtl/seq_counter.sv
module seq_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

  // R4: the count never wraps from zero
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import startup_seq_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int SET_W    = 16,
  parameter int SYNC_LEN = 4,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [SET_W-1:0] cfg_settle,
  input  logic             tb_locked,
  input  logic             seq_begin,
  input  logic             rate_stb,
  input  logic             start_cmd,
  input  logic             abort,
  input  logic             sync_in,
  input  logic             trig_in,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             cnt_dec,
  output seq_state_e       state,
  output logic             mode_master,
  output logic             fire
);
  seq_state_e state_q, state_d;
  logic       mode_q, mode_d;
  logic       pend_q, pend_d;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    pend_d   = pend_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    cnt_dec  = 1'b0;
    fire     = 1'b0;
    if (abort) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (seq_begin && tb_locked) begin
            state_d  = ST_SYNC;
            mode_d   = cfg_master;
            pend_d   = 1'b0;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(SYNC_LEN - 1);
          end
        end
        ST_SYNC: begin
          if (mode_q) begin
            if (start_cmd) pend_d = 1'b1;
            if (cnt_zero) begin
              state_d  = ST_SETTLE;
              cnt_load = 1'b1;
              cnt_val  = CNT_W'(cfg_delay);
            end else begin
              cnt_dec = 1'b1;
            end
          end else if (sync_in) begin
            state_d  = ST_SETTLE;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(cfg_settle);
          end
        end
        ST_SETTLE: begin
          if (mode_q && start_cmd) pend_d = 1'b1;
          if (cnt_zero) begin
            if (mode_q && (pend_q || start_cmd)) begin
              state_d = ST_RUN;
              fire    = 1'b1;
            end else begin
              state_d = ST_ARMED;
            end
          end else begin
            cnt_dec = rate_stb;
          end
        end
        ST_ARMED: begin
          if (mode_q) begin
            if (start_cmd) begin
              state_d = ST_RUN;
              fire    = 1'b1;
            end
          end else if (trig_in) begin
            state_d = ST_RUN;
          end
        end
        ST_RUN:  state_d = ST_RUN;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      pend_q  <= pend_d;
    end
  end

  assign state       = state_q;
  assign mode_master = mode_q;

  // R10: abort always lands in IDLE
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state_q == ST_IDLE));
  // R2: no progress out of IDLE without lock
  p_need_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !tb_locked) |=> (state_q == ST_IDLE));
  // R7: a slave waits for the imported sync
  p_slave_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SYNC && !mode_q && !sync_in && !abort) |=> (state_q == ST_SYNC));
  // R9: a master ignores an imported trigger while armed
  p_master_no_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && mode_q && !start_cmd && !abort) |=> (state_q == ST_ARMED));
endmodule

// File: rtl/seq_outputs.sv
module seq_outputs
  import startup_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state,
  input  logic       mode_master,
  input  logic       fire,
  output logic       sync_out,
  output logic       trig_out,
  output logic       conv_rst,
  output logic       armed,
  output logic       running,
  output logic [2:0] seq_state
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= fire;
  end

  assign sync_out  = mode_master && (state == ST_SYNC);
  assign conv_rst  = (state == ST_SETTLE) || (mode_master && (state == ST_SYNC));
  assign armed     = (state == ST_ARMED);
  assign running   = (state == ST_RUN);
  assign trig_out  = trig_q;
  assign seq_state = state;

  // R3: the exported sync always comes with local converter reset
  p_sync_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> conv_rst);
  // R5: trigger only in the first running cycle
  p_trig_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> running);
  p_trig_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |=> !trig_out);
  // R11: armed and running are exclusive
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, running, conv_rst && !sync_out && armed}));
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_seq_pkg::*;
#(
  parameter int DLY_W    = 16,
  parameter int SET_W    = 16,
  parameter int SYNC_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [SET_W-1:0] cfg_settle,
  input  logic             tb_locked,
  input  logic             seq_begin,
  input  logic             rate_stb,
  input  logic             start_cmd,
  input  logic             abort,
  input  logic             sync_in,
  input  logic             trig_in,
  output logic             sync_out,
  output logic             trig_out,
  output logic             conv_rst,
  output logic             armed,
  output logic             running,
  output logic [2:0]       seq_state
);
  localparam int SYNC_W = $clog2(SYNC_LEN) + 1;
  localparam int CFG_W  = (DLY_W > SET_W) ? DLY_W : SET_W;
  localparam int CNT_W  = (CFG_W > SYNC_W) ? CFG_W : SYNC_W;

  logic             cnt_load, cnt_dec, cnt_zero, mode_master, fire;
  logic [CNT_W-1:0] cnt_val;
  seq_state_e       state;

  seq_fsm #(
    .DLY_W(DLY_W), .SET_W(SET_W), .SYNC_LEN(SYNC_LEN), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_delay(cfg_delay),
    .cfg_settle(cfg_settle), .tb_locked(tb_locked), .seq_begin(seq_begin),
    .rate_stb(rate_stb), .start_cmd(start_cmd), .abort(abort),
    .sync_in(sync_in), .trig_in(trig_in), .cnt_zero(cnt_zero),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .cnt_dec(cnt_dec),
    .state(state), .mode_master(mode_master), .fire(fire)
  );

  seq_counter #(.W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
    .dec(cnt_dec), .zero(cnt_zero)
  );

  seq_outputs out_i (
    .clk(clk), .rst_n(rst_n), .state(state), .mode_master(mode_master),
    .fire(fire), .sync_out(sync_out), .trig_out(trig_out),
    .conv_rst(conv_rst), .armed(armed), .running(running),
    .seq_state(seq_state)
  );

  // R8: a slave never exports sync or trigger
  p_slave_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !mode_master) |-> (!sync_out && !trig_out));
endmodule

// File: tb/startup_seq_tb_top.sv
module startup_seq_tb_top;
  localparam int SYNC_LEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b0;
  logic [15:0] cfg_delay = '0;
  logic [15:0] cfg_settle = '0;
  logic tb_locked = 1'b0, seq_begin = 1'b0, rate_stb = 1'b0, start_cmd = 1'b0;
  logic abort = 1'b0, sync_in = 1'b0, trig_in = 1'b0;
  logic sync_out, trig_out, conv_rst, armed, running;
  logic [2:0] seq_state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  startup_seq #(.DLY_W(16), .SET_W(16), .SYNC_LEN(SYNC_LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_delay(cfg_delay),
    .cfg_settle(cfg_settle), .tb_locked(tb_locked), .seq_begin(seq_begin),
    .rate_stb(rate_stb), .start_cmd(start_cmd), .abort(abort),
    .sync_in(sync_in), .trig_in(trig_in), .sync_out(sync_out),
    .trig_out(trig_out), .conv_rst(conv_rst), .armed(armed),
    .running(running), .seq_state(seq_state)
  );

  // behavioural reference: state names as integers
  int m_st = 0, m_cnt = 0;
  bit m_mode = 0, m_pend = 0, m_trig = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_mode = 0; m_pend = 0; m_trig = 0;
    end else begin
      bit go;
      go = 0;
      if (abort) begin
        m_st = 0; m_pend = 0;
      end else if (m_st == 0) begin
        if (seq_begin && tb_locked) begin
          m_st = 1; m_mode = cfg_master; m_pend = 0; m_cnt = SYNC_LEN - 1;
        end
      end else if (m_st == 1) begin
        if (m_mode) begin
          if (start_cmd) m_pend = 1;
          if (m_cnt == 0) begin m_st = 2; m_cnt = int'(cfg_delay); end
          else m_cnt--;
        end else if (sync_in) begin
          m_st = 2; m_cnt = int'(cfg_settle);
        end
      end else if (m_st == 2) begin
        if (m_cnt == 0) begin
          if (m_mode && (m_pend || start_cmd)) begin m_st = 4; go = 1; end
          else m_st = 3;
        end else begin
          if (m_mode && start_cmd) m_pend = 1;
          if (rate_stb) m_cnt--;
        end
      end else if (m_st == 3) begin
        if (m_mode && start_cmd) begin m_st = 4; go = 1; end
        else if (!m_mode && trig_in) m_st = 4;
      end
      m_trig = go;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R11 state", int'(seq_state), m_st);
      check("R3 sync_out", int'(sync_out), int'(m_mode && m_st == 1));
      check("R3 conv_rst", int'(conv_rst), int'(m_st == 2 || (m_mode && m_st == 1)));
      check("R5 trig_out", int'(trig_out), int'(m_trig));
      check("R11 armed", int'(armed), int'(m_st == 3));
      check("R11 running", int'(running), int'(m_st == 4));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_stb();
    rate_stb = 1'b1; tick(1); rate_stb = 1'b0;
  endtask

  task automatic do_abort();
    abort = 1'b1; tick(1); abort = 1'b0;
  endtask

  task automatic begin_seq(input bit master);
    cfg_master = master; seq_begin = 1'b1; tick(1); seq_begin = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int syn_hi;
    int trig_cnt;
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 state", int'(seq_state), 0);
    check("R1 outputs", int'({sync_out, trig_out, conv_rst, armed, running}), 0);
    tick(1);

    // R2 begin without lock is ignored
    begin_seq(1'b1);
    @(negedge clk);
    check("R2 no lock", int'(seq_state), 0);
    tb_locked = 1'b1;
    tick(1);

    // master: delay 3 strobes, count the sync cycles
    cfg_delay = 16'd3;
    begin_seq(1'b1);
    syn_hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sync_out) syn_hi++;
      if (seq_state == 3'd2) break;
      tick(1);
    end
    check("R3 sync length", syn_hi, SYNC_LEN);
    tick(1);
    pulse_stb(); tick(2); pulse_stb();
    @(negedge clk);
    check("R4 still settling", int'(seq_state), 2);
    tick(1); pulse_stb();
    @(negedge clk);
    check("R4 last strobe", int'(seq_state), 2);
    tick(1);
    @(negedge clk);
    check("R4 armed after delay", int'(armed), 1);
    // R9 trig_in while master armed is ignored
    trig_in = 1'b1; tick(1); trig_in = 1'b0;
    @(negedge clk);
    check("R9 master ignores trig_in", int'(seq_state), 3);
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    @(negedge clk);
    check("R5 running", int'(running), 1);
    check("R5 trig_out", int'(trig_out), 1);
    tick(1);
    @(negedge clk);
    check("R5 trig one cycle", int'(trig_out), 0);
    do_abort();
    @(negedge clk);
    check("R10 abort from run", int'(seq_state), 0);

    // R6 early start with delay 0 (R4 one cycle of settling)
    cfg_delay = 16'd0;
    begin_seq(1'b1);
    tick(1);
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    trig_cnt = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (trig_out) trig_cnt++;
      tick(1);
    end
    check("R6 held start ran", int'(running), 1);
    check("R6 one trigger", trig_cnt, 1);
    do_abort();

    // R10 abort discards a held start
    cfg_delay = 16'd2;
    begin_seq(1'b1);
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    do_abort();
    @(negedge clk);
    check("R10 abort from sync", int'(seq_state), 0);
    begin_seq(1'b1);
    tick(SYNC_LEN);
    pulse_stb(); pulse_stb(); tick(2);
    @(negedge clk);
    check("R10 held start cleared", int'(seq_state), 3);
    do_abort();

    // R6 start in the very cycle of expiry
    cfg_delay = 16'd1;
    begin_seq(1'b1);
    tick(SYNC_LEN);
    pulse_stb();
    start_cmd = 1'b1; tick(1); start_cmd = 1'b0;
    @(negedge clk);
    check("R6 start at expiry", int'(running), 1);
    do_abort();

    // slave path
    cfg_settle = 16'd5;
    begin_seq(1'b0);
    tick(4);
    @(negedge clk);
    check("R7 waiting", int'(seq_state), 1);
    check("R7 no reset while waiting", int'(conv_rst), 0);
    trig_in = 1'b1; tick(1); trig_in = 1'b0;
    @(negedge clk);
    check("R9 trig_in before arm", int'(seq_state), 1);
    sync_in = 1'b1; tick(2); sync_in = 1'b0;
    @(negedge clk);
    check("R7 settling reset", int'(conv_rst), 1);
    for (int i = 0; i < 5; i++) begin
      trig_in = (i == 2); pulse_stb(); trig_in = 1'b0; tick(1);
    end
    @(negedge clk);
    check("R7 slave armed", int'(armed), 1);
    start_cmd = 1'b1; tick(2); start_cmd = 1'b0;
    @(negedge clk);
    check("R8 start_cmd ignored", int'(seq_state), 3);
    trig_in = 1'b1; tick(1); trig_in = 1'b0;
    @(negedge clk);
    check("R8 slave running", int'(running), 1);
    check("R8 no trig_out", int'(trig_out), 0);
    do_abort();
    tick(2);
    finish_run();
  end
endmodule